// File: doc/BRIEF.md
# Byte-Serial SPN Keystream Engine

This block is the datapath and sequencer of a byte-wide substitution-permutation stream generator. It keeps a 37-byte working state, an 8-bit chaining accumulator and a single 8-bit substitution box. On every clock it runs exactly one sub-round. The sub-round takes the state byte under a rotating state pointer, mixes it with the accumulator and with the key byte supplied by a separate key-register block, and substitutes the result. The substituted byte becomes the new accumulator value and is also written back over the state byte it came from.

Software loads the IV, an accumulator seed and a state-pointer seed in one parallel load, and the engine then stays armed until it sees a start pulse. After start it runs ten rounds of initialization. Each round is one sub-round per state byte. It then keeps running groups of three stream rounds. After each group it presents a block of 16 keystream bytes, one byte per clock, with a valid strobe. The engine never stops between sub-rounds. The key-register block is told to step through a strobe on each sub-round, and it must present the next key byte by the following clock.

Top module: `spnks_core`

## Requirements
- R1: A `load` pulse while not running captures all 37 IV bytes in parallel (byte j from `iv_bytes[8j+7:8j]`), the accumulator seed, and the pointer seed reduced modulo 37. The engine then stays armed with `key_step` and `busy` low until a start pulse arrives.
- R2: `start` has no effect unless the engine is armed. While the engine is running, both `load` and `start` are ignored, and the keystream is unchanged by them.
- R3: In every running cycle the engine executes one sub-round. It forms v = S(state[p] ^ acc ^ key_byte), where S is the standard AES forward S-box. Both acc and state[p] take v. `key_step` is high on exactly those cycles, and it stays high on every cycle from the cycle after start with no gaps.
- R4: The state pointer p advances by one per sub-round and wraps from 36 to 0.
- R5: The first keystream byte is valid exactly 481 clocks after the clock edge that samples `start`. `ks_valid` then stays high for exactly 16 consecutive cycles.
- R6: Byte i (0 to 15) of a block equals state[(q + 2i) mod 37] as it stands when the block's last sub-round completes. Here q is the pointer value after that sub-round, which points at the oldest byte. Later sub-rounds never change a byte before it has been presented.
- R7: Each further block starts 111 clocks after the start of the block before it.
- R8: `busy` goes high on the cycle after start is accepted, stays high until the first block becomes valid, and is low from the first valid cycle onward.
- R9: While `rst_n` is low at a clock edge, the accumulator, the pointers and the control state are cleared. `ks_valid`, `busy` and `key_step` are low after that edge, and the engine must be loaded again before a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Parallel load of IV, accumulator seed and pointer seed |
| iv_bytes | input | 296 | 37 IV bytes, byte j in bits 8j+7..8j |
| accu_seed | input | 8 | Initial accumulator value |
| ptr_seed | input | 6 | Initial state pointer, taken modulo 37 |
| start | input | 1 | Start command, accepted only when armed |
| key_byte | input | 8 | Current key byte from the key-register block |
| key_step | output | 1 | Sub-round strobe; the key block advances on it |
| ks_byte | output | 8 | Keystream byte, zero when not valid |
| ks_valid | output | 1 | Keystream byte valid |
| busy | output | 1 | High from start until the first block is valid |

## Verification
The assertions assume that `key_byte` is settled before each clock edge on which `key_step` is high, and that the key block follows the strobe with no handshake of its own. The bench meets this with a stub key register: it holds sixteen fixed bytes, advances its index by three on every strobe, and is rewound only when the engine is loaded. All inputs change half a cycle away from the sampling edge. Load and start are single-cycle pulses, except for the deliberate overlapping pulses that check R2. The output-read checks also rely on the default geometry (stride 2, 16 bytes, 37 state bytes), under which the read pointer always stays ahead of the write pointer during a block.

// File: rtl/spnks_pkg.sv
// Shared types and the substitution function of the keystream engine.
// Assumes: byte-wide datapath; the S-box is the AES forward substitution,
// computed as the GF(2^8) inverse followed by the affine map.
package spnks_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_RUN   = 2'd2
    } phase_t;

    // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1.
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // Full GF(2^8) product by shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Inverse as x^254; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] r;
        logic [7:0] base;
        logic [7:0] e;
        r    = 8'h01;
        base = x;
        e    = 8'hfe;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    // Forward substitution: inverse, then affine transform with constant 0x63.
    function automatic logic [7:0] fwd_sub(input logic [7:0] x);
        logic [7:0] b;
        b = gf_inv(x);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/spnks_sbox.sv
// Single 8-bit substitution box, purely combinational.
// Assumes: used once per sub-round on the chaining path; no pipelining.
module spnks_sbox (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    // Combinational lookup computed by the package function.
    always_comb dout = spnks_pkg::fwd_sub(din);
endmodule

// File: rtl/spnks_state_file.sv
// Byte-addressed working state with a parallel load port, one write port
// and two independent read ports (sub-round operand and keystream output).
// Assumes: load and write never coincide (the controller guarantees it);
// pointers are below NB. Storage is data only and carries no reset.
module spnks_state_file #(
    parameter  int NB = 37,
    localparam int PW = $clog2(NB)
) (
    input  logic            clk,
    input  logic            ld,
    input  logic [NB*8-1:0] ld_data,
    input  logic            wr_en,
    input  logic [PW-1:0]   wr_ptr,
    input  logic [7:0]      wr_data,
    input  logic [PW-1:0]   rd_a_ptr,
    output logic [7:0]      rd_a_data,
    input  logic [PW-1:0]   rd_b_ptr,
    output logic [7:0]      rd_b_data
);
    logic [7:0] mem [NB];

    // Parallel capture on load, otherwise a single-byte write at wr_ptr.
    always_ff @(posedge clk) begin
        for (int j = 0; j < NB; j++) begin
            if (ld) begin
                mem[j] <= ld_data[8*j +: 8];
            end else if (wr_en && (wr_ptr == PW'(j))) begin
                mem[j] <= wr_data;
            end
        end
    end

    // Operand read port selected by the state pointer.
    always_comb begin
        rd_a_data = 8'h00;
        for (int j = 0; j < NB; j++) begin
            if (rd_a_ptr == PW'(j)) rd_a_data = mem[j];
        end
    end

    // Output read port selected by the output pointer.
    always_comb begin
        rd_b_data = 8'h00;
        for (int j = 0; j < NB; j++) begin
            if (rd_b_ptr == PW'(j)) rd_b_data = mem[j];
        end
    end
endmodule

// File: rtl/spnks_ctrl.sv
// Sequencer: arm/run phases, state pointer, sub-round countdown to each
// block, and the strided output pointer with its 16-byte emission window.
// Assumes: STRIDE*(BLK-1) < NB and STRIDE >= 2, so reads outrun writes.
module spnks_ctrl #(
    parameter  int NB            = 37,
    parameter  int BLK           = 16,
    parameter  int INIT_ROUNDS   = 10,
    parameter  int STREAM_ROUNDS = 3,
    parameter  int STRIDE        = 2,
    localparam int PW            = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          start,
    input  logic [PW-1:0] ptr_seed,
    output logic          step,
    output logic          ld_ok,
    output logic          emit,
    output logic          busy,
    output logic [PW-1:0] p1,
    output logic [PW-1:0] po
);
    import spnks_pkg::*;

    localparam int FIRST = NB * (INIT_ROUNDS + STREAM_ROUNDS);
    localparam int GAP   = NB * STREAM_ROUNDS;
    localparam int CW    = $clog2(FIRST + 1);
    localparam int EW    = $clog2(BLK + 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [EW-1:0] emit_cnt;
    logic          go;
    logic          blk_done;
    logic [PW-1:0] p1_nxt;
    logic [PW-1:0] po_nxt;
    logic [PW-1:0] seed_mod;
    logic [PW:0]   po_sum;
    logic [PW:0]   seed_ext;

    // Decode of phase-dependent strobes and pointer successors.
    always_comb begin
        ld_ok    = load && (phase != PH_RUN);
        go       = start && !load && (phase == PH_ARMED);
        step     = (phase == PH_RUN);
        blk_done = step && (cnt == CW'(1));
        emit     = (emit_cnt != '0);
        p1_nxt   = (p1 == PW'(NB - 1)) ? '0 : p1 + 1'b1;
        po_sum   = {1'b0, po} + (PW+1)'(STRIDE);
        po_nxt   = (po_sum >= (PW+1)'(NB)) ? PW'(po_sum - (PW+1)'(NB)) : PW'(po_sum);
        seed_ext = {1'b0, ptr_seed};
        seed_mod = (seed_ext >= (PW+1)'(NB)) ? PW'(seed_ext - (PW+1)'(NB)) : ptr_seed;
    end

    // Phase register and state pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            p1    <= '0;
        end else if (ld_ok) begin
            phase <= PH_ARMED;
            p1    <= seed_mod;
        end else if (go) begin
            phase <= PH_RUN;
        end else if (step) begin
            p1 <= p1_nxt;
        end
    end

    // Countdown of sub-rounds to the next completed block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (go) begin
            cnt <= CW'(FIRST);
        end else if (blk_done) begin
            cnt <= CW'(GAP);
        end else if (step) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Emission window and strided output pointer from the oldest byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_cnt <= '0;
            po       <= '0;
        end else if (blk_done) begin
            emit_cnt <= EW'(BLK);
            po       <= p1_nxt;
        end else if (emit) begin
            emit_cnt <= emit_cnt - 1'b1;
            po       <= po_nxt;
        end
    end

    // Busy from an accepted start until the first block is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (go) begin
            busy <= 1'b1;
        end else if (blk_done) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/spnks_core.sv
// Top of the byte-serial keystream engine: one sub-round per clock through
// state byte, accumulator, external key byte and the S-box, with a strided
// keystream read from the live state.
// Assumes: key_byte is valid in every cycle key_step is high and the key
// block advances on that strobe.
module spnks_core #(
    parameter  int NB            = 37,
    parameter  int BLK           = 16,
    parameter  int INIT_ROUNDS   = 10,
    parameter  int STREAM_ROUNDS = 3,
    parameter  int STRIDE        = 2,
    localparam int PW            = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NB*8-1:0] iv_bytes,
    input  logic [7:0]      accu_seed,
    input  logic [PW-1:0]   ptr_seed,
    input  logic            start,
    input  logic [7:0]      key_byte,
    output logic            key_step,
    output logic [7:0]      ks_byte,
    output logic            ks_valid,
    output logic            busy
);
    logic          ld_ok;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] out_ptr;
    logic [7:0]    accu;
    logic [7:0]    st_byte;
    logic [7:0]    out_byte;
    logic [7:0]    sb_in;
    logic [7:0]    sb_out;

    spnks_ctrl #(
        .NB(NB), .BLK(BLK), .INIT_ROUNDS(INIT_ROUNDS),
        .STREAM_ROUNDS(STREAM_ROUNDS), .STRIDE(STRIDE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .start(start),
        .ptr_seed(ptr_seed), .step(key_step), .ld_ok(ld_ok),
        .emit(ks_valid), .busy(busy), .p1(rd_ptr), .po(out_ptr)
    );

    spnks_state_file #(.NB(NB)) u_state (
        .clk(clk), .ld(ld_ok), .ld_data(iv_bytes),
        .wr_en(key_step), .wr_ptr(rd_ptr), .wr_data(sb_out),
        .rd_a_ptr(rd_ptr), .rd_a_data(st_byte),
        .rd_b_ptr(out_ptr), .rd_b_data(out_byte)
    );

    // Chaining input to the S-box.
    always_comb sb_in = st_byte ^ accu ^ key_byte;

    spnks_sbox u_sbox (.din(sb_in), .dout(sb_out));

    // Accumulator: seeded on load, takes the substituted byte each sub-round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accu <= 8'h00;
        end else if (ld_ok) begin
            accu <= accu_seed;
        end else if (key_step) begin
            accu <= sb_out;
        end
    end

    // Keystream byte gated by its valid strobe.
    always_comb ks_byte = ks_valid ? out_byte : 8'h00;
endmodule

// File: rtl/spnks_core_chk.sv
// Temporal checks on the keystream engine, bound into every instance.
// Assumes: default geometry, so strided reads lead the pointer.
module spnks_core_chk #(
    parameter  int NB     = 37,
    parameter  int BLK    = 16,
    parameter  int STRIDE = 2,
    localparam int PW     = $clog2(NB),
    localparam int EW     = $clog2(BLK + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          key_step,
    input logic          ks_valid,
    input logic          busy,
    input logic [PW-1:0] p1,
    input logic [PW-1:0] po
);
    logic [EW-1:0] run_len;

    // Length of the current run of valid bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else if (ks_valid) run_len <= run_len + 1'b1;
        else run_len <= '0;
    end

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_step |=> (p1 == PW'((int'($past(p1)) + 1) % NB)));

    // R3
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_step |=> key_step);

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_step) |-> $past(start));

    // R8
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ks_valid);

    // R5
    block_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> (run_len < EW'(BLK)));

    // R5
    block_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ks_valid) |-> ($past(run_len) == EW'(BLK - 1)));

    // R6
    out_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && $past(ks_valid)) |->
            (po == PW'((int'($past(po)) + STRIDE) % NB)));

    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && $past(ks_valid)) |-> (po != p1));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ks_valid && !busy && !key_step));
endmodule

bind spnks_core spnks_core_chk #(.NB(NB), .BLK(BLK), .STRIDE(STRIDE)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .key_step(key_step),
    .ks_valid(ks_valid), .busy(busy), .p1(rd_ptr), .po(out_ptr)
);

// File: tb/spnks_core_tb.sv
module spnks_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 37;
    localparam int T_FIRST = 481;
    localparam int T_GAP = 111;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load = 1'b0;
    logic [NB*8-1:0] iv_bytes = '0;
    logic [7:0]      accu_seed = 8'h00;
    logic [5:0]      ptr_seed = 6'd0;
    logic            start = 1'b0;
    logic [7:0]      key_byte;
    logic            key_step;
    logic [7:0]      ks_byte;
    logic            ks_valid;
    logic            busy;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] tb_sbox [256];
    logic [7:0] kreg [16];
    logic [3:0] p2;
    logic       kreset = 1'b0;
    logic [7:0] m_st [NB];
    logic [7:0] m_accu;
    int         m_p1;
    int         m_k;

    always #(CLK_PERIOD/2) clk = ~clk;

    spnks_core u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .iv_bytes(iv_bytes),
        .accu_seed(accu_seed), .ptr_seed(ptr_seed), .start(start),
        .key_byte(key_byte), .key_step(key_step), .ks_byte(ks_byte),
        .ks_valid(ks_valid), .busy(busy)
    );

    // Stub key block: index steps by three on each strobe.
    always @(posedge clk) begin
        if (!rst_n || kreset) p2 <= 4'd0;
        else if (key_step) p2 <= p2 + 4'd3;
    end
    assign key_byte = kreg[p2];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [14:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
        for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11b << (i - 8));
        return p[7:0];
    endfunction

    task automatic build_sbox();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv;
            logic [7:0] r;
            inv = 8'h00;
            for (int b = 1; b < 256; b++)
                if (a != 0 && bmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            for (int i = 0; i < 8; i++)
                r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
            tb_sbox[a] = r;
        end
    endtask

    task automatic m_step();
        logic [7:0] v;
        v = tb_sbox[m_st[m_p1] ^ m_accu ^ kreg[m_k]];
        m_accu = v;
        m_st[m_p1] = v;
        m_p1 = (m_p1 + 1) % NB;
        m_k = (m_k + 3) % 16;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; load = 1'b0; start = 1'b0; kreset = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R9: outputs quiet after reset.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "valid in reset", 32'(ks_valid), 0);
        chk("R9", "busy in reset", 32'(busy), 0);
        chk("R9", "step in reset", 32'(key_step), 0);
        rst_n = 1'b1;
    endtask

    // R2: start without a load is ignored.
    task automatic t_start_unarmed();
        int steps;
        do_reset();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        steps = 0;
        repeat (6) begin
            @(negedge clk);
            if (key_step || busy) steps++;
        end
        chk("R2", "unarmed start activity", 32'(steps), 0);
    endtask

    task automatic run_case(input string req, input logic [7:0] iv_mul,
                            input logic [7:0] iv_add, input logic [7:0] aseed,
                            input logic [5:0] pseed, input bit poke);
        logic [7:0] expb [3][16];
        logic [NB*8-1:0] iv;
        int bad_step, bad_valid, bad_busy, first_bad, first_v, second_v, armed_act;
        do_reset();
        for (int j = 0; j < NB; j++) begin
            iv[8*j +: 8] = 8'(j * iv_mul + iv_add);
            m_st[j] = 8'(j * iv_mul + iv_add);
        end
        m_accu = aseed;
        m_p1 = int'(pseed) % NB;
        m_k = 0;
        for (int b = 0; b < 3; b++) begin
            for (int n = 0; n < ((b == 0) ? T_FIRST : T_GAP); n++) m_step();
            for (int i = 0; i < 16; i++) expb[b][i] = m_st[(m_p1 + 2*i) % NB];
        end
        @(negedge clk);
        load = 1'b1; iv_bytes = iv; accu_seed = aseed; ptr_seed = pseed; kreset = 1'b1;
        @(negedge clk);
        load = 1'b0; kreset = 1'b0; iv_bytes = '0; accu_seed = 8'h00; ptr_seed = 6'd0;
        armed_act = 0;
        repeat (6) begin
            @(negedge clk);
            if (key_step || busy) armed_act++;
        end
        chk("R1", "armed waits for start", 32'(armed_act), 0);
        start = 1'b1;
        bad_step = 0; bad_valid = 0; bad_busy = 0; first_bad = -1; first_v = -1; second_v = -1;
        for (int cyc = 0; cyc <= T_FIRST + 2*T_GAP + 20; cyc++) begin
            int bi;
            int idx;
            @(negedge clk);
            bi = -1; idx = 0;
            for (int b = 0; b < 3; b++)
                if (cyc >= T_FIRST + b*T_GAP && cyc < T_FIRST + b*T_GAP + 16) begin
                    bi = b; idx = cyc - T_FIRST - b*T_GAP;
                end
            if (key_step !== 1'b1) bad_step++;
            if (busy !== (cyc < T_FIRST)) bad_busy++;
            if (ks_valid !== (bi >= 0)) begin
                bad_valid++;
                if (first_bad < 0) first_bad = cyc;
            end
            if (ks_valid && first_v < 0) first_v = cyc;
            if (ks_valid && cyc > T_FIRST + 16 && second_v < 0) second_v = cyc;
            if (bi >= 0) chk(req, $sformatf("block %0d byte %0d", bi, idx), 32'(ks_byte), 32'(expb[bi][idx]));
            if (cyc == 0) start = 1'b0;
            if (poke && cyc == 200) begin
                load = 1'b1; start = 1'b1; iv_bytes = '1; accu_seed = 8'h3c; ptr_seed = 6'd5;
            end
            if (poke && cyc == 201) begin
                load = 1'b0; start = 1'b0; iv_bytes = '0; accu_seed = 8'h00; ptr_seed = 6'd0;
            end
        end
        chk("R3", "cycles without step", 32'(bad_step), 0);
        chk("R8", "busy mismatches", 32'(bad_busy), 0);
        chk("R5", "valid mismatches", 32'(bad_valid), 0);
        if (bad_valid != 0) chk("R5", "first valid mismatch cycle", 32'(first_bad), 32'(-1));
        chk("R5", "first valid cycle", 32'(first_v), 32'(T_FIRST));
        chk("R7", "second block cycle", 32'(second_v), 32'(T_FIRST + T_GAP));
    endtask

    // R9: reset in mid-run clears outputs and drops the armed state.
    task automatic t_reset_mid();
        int act;
        do_reset();
        @(negedge clk) begin load = 1'b1; kreset = 1'b1; end
        @(negedge clk) begin load = 1'b0; kreset = 1'b0; start = 1'b1; end
        @(negedge clk) start = 1'b0;
        repeat (50) @(negedge clk);
        chk("R3", "running before reset", 32'(key_step), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "step after mid reset", 32'(key_step), 0);
        chk("R9", "busy after mid reset", 32'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        act = 0;
        repeat (5) begin
            @(negedge clk);
            if (key_step) act++;
        end
        chk("R9", "start after reset without load", 32'(act), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) kreg[i] = 8'(i * 29 + 71);
        build_sbox();
        t_reset();
        t_start_unarmed();
        run_case("R6", 8'd7, 8'd3, 8'h00, 6'd0, 1'b0);
        run_case("R4", 8'd13, 8'ha5, 8'hff, 6'd36, 1'b1);
        run_case("R1", 8'd0, 8'd0, 8'h5a, 6'd50, 1'b0);
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule